// File: doc/BRIEF.md
# Programmable Down-Count Timer Channel

One countdown channel driven by an external 1 µs strobe. Software arms it with a single word that holds an enable flag, a mode flag and a load value. While armed, the channel steps its count down by one on each strobe. A load value of N makes it expire on the (N+1)-th strobe. When it expires, it raises a level interrupt. In one-shot mode it then disarms. In periodic mode it reloads and keeps running, so a load of (1,000,000 / rate) − 1 yields the chosen rate from a 1 MHz strobe. A driver that wants C strobes programs C − 1, or 0 when C ≤ 1.

A second word gives the remaining count and the pending flag. Writing the clear bit of that word drops the interrupt. Reading it never does. Writing an all-zero control word stops the channel, and software does this before reprogramming. A system that needs several channels instantiates several copies, each with its own strobe and interrupt line.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `irq_o` is 0 and both the control word and the status word read back as 0.
- R2: A control write (`reg_sel_i`=0) stores enable from bit 31, periodic mode from bit 30 and the load value from bits 28:0, and starts the count at the load value. Reading the control word returns those three fields in the same positions, with every other bit 0.
- R3: While the channel is enabled, each cycle with `tick_i`=1 lowers the count by one. While it is disabled, ticks leave the count unchanged.
- R4: With load value N, `irq_o` rises in the cycle after the (N+1)-th tick. A load of 0 expires on the first tick.
- R5: In one-shot mode (bit 30 = 0), expiry clears the enable bit and the count stays at 0 under further ticks.
- R6: In periodic mode (bit 30 = 1), expiry reloads the count with the load value, and the channel expires again after every further N+1 ticks.
- R7: Writing an all-zero control word stops the channel: the count reads 0 and no tick raises the interrupt.
- R8: A control write while the channel is running restarts the count from the new load value. If the write and a tick arrive in the same cycle, the write wins.
- R9: Reading the status word (`reg_sel_i`=1) returns the remaining count in bits 28:0 and the pending flag in bit 30. Reading does not clear the interrupt.
- R10: A status write with bit 30 = 1 clears the pending interrupt. A status write with bit 30 = 0 has no effect. If an expiry and a clear happen in the same cycle, the interrupt stays set.
- R11: `irq_o` is active-high and level. Once set, it stays at 1 until it is cleared.
- R12: The full 29-bit load value 0x1FFFFFFF is accepted: it reads back intact and counts down from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, one per microsecond |
| reg_sel_i | input | 1 | Word select: 0 = control, 1 = status |
| wr_en_i | input | 1 | Write strobe for the selected word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected word (combinational) |
| irq_o | output | 1 | Level interrupt, active-high |

## Verification
The bench builds the channel with its default widths: a 29-bit count in a 32-bit word. This places the enable, mode and clear flags at bits 31 and 30, with bit 29 left unused, so the bench can show that the unused bit is dropped. Because the strobe is a bench input rather than a divided clock, short loads (0, 1, 2, 3, 5) let it reach expiry, reload, restart and collisions between the strobe and a write within a few cycles. The all-ones 29-bit load is checked by reading it back and by one decrement rather than by a full countdown.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Register word select
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } tmr_sel_e;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_wr_i,
    input  logic             load_en_i,
    input  logic             load_per_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             en_o,
    output logic             per_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    typedef struct packed {
        logic             en;
        logic             per;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_wr_i) begin
            st_d.en   = load_en_i;
            st_d.per  = load_per_i;
            st_d.load = load_val_i;
            st_d.cnt  = load_val_i;
        end else if (st_q.en && tick_i) begin
            if (st_q.cnt == '0) begin
                expire_o = 1'b1;
                if (st_q.per) st_d.cnt = st_q.load;
                else          st_d.en  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign per_o  = st_q.per;
    assign load_o = st_q.load;
    assign cnt_o  = st_q.cnt;

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && tick_i && !load_wr_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !load_wr_i) |=> $stable(cnt_o)); // R3
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !per_o && tick_i && !load_wr_i && cnt_o == '0) |=> (!en_o && cnt_o == '0)); // R5
    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && per_o && tick_i && !load_wr_i && cnt_o == '0) |=> (en_o && cnt_o == load_o)); // R6
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> (cnt_o == $past(load_val_i) && en_o == $past(load_en_i))); // R8
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.pend = 1'b1;
        else if (clr_i) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.pend;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o); // R11
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o); // R10
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import tmr_pkg::*;

    localparam int EN_BIT  = DATA_W - 1;
    localparam int PER_BIT = DATA_W - 2;
    localparam int CLR_BIT = DATA_W - 2;

    logic             ctrl_wr, stat_clr, expire;
    logic             en, per;
    logic [CNT_W-1:0] load, cnt;
    logic             unused_gap;

    assign ctrl_wr    = wr_en_i && (tmr_sel_e'(reg_sel_i) == SEL_CTRL);
    assign stat_clr   = wr_en_i && (tmr_sel_e'(reg_sel_i) == SEL_STAT) && wr_data_i[CLR_BIT];
    assign unused_gap = ^wr_data_i[PER_BIT-1:CNT_W];

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_wr_i  (ctrl_wr),
        .load_en_i  (wr_data_i[EN_BIT]),
        .load_per_i (wr_data_i[PER_BIT]),
        .load_val_i (wr_data_i[CNT_W-1:0]),
        .en_o       (en),
        .per_o      (per),
        .load_o     (load),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    tmr_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (expire),
        .clr_i (stat_clr),
        .irq_o (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (tmr_sel_e'(reg_sel_i) == SEL_CTRL) begin
            rd_data_o[EN_BIT]    = en;
            rd_data_o[PER_BIT]   = per;
            rd_data_o[CNT_W-1:0] = load;
        end else begin
            rd_data_o[CLR_BIT]   = irq_o;
            rd_data_o[CNT_W-1:0] = cnt;
        end
    end

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data_i == '0) |=> (!en && cnt == '0)); // R7
endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;

    tmr_channel uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_sel_i(reg_sel_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: optional tick and optional write, ends at a falling edge
    task automatic cyc(input logic tk, input logic we, input logic sel, input logic [31:0] d);
        tick_i = tk; wr_en_i = we; reg_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic rd(input string req, input logic sel, input logic [31:0] exp);
        reg_sel_i = sel;
        #1;
        chk(req, rd_data_o, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rd("R1 ctrl", 1'b0, 32'h0);
        rd("R1 stat", 1'b1, 32'h0);
    endtask

    task automatic t_fields();
        cyc(1'b0, 1'b1, 1'b0, 32'hC000_0005);
        rd("R2 ctrl readback", 1'b0, 32'hC000_0005);
        cyc(1'b0, 1'b1, 1'b0, 32'h2000_0007);
        rd("R2 bit29 dropped", 1'b0, 32'h0000_0007);
        ticks(3);
        rd("R3 disabled ticks ignored", 1'b1, 32'h0000_0007);
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_oneshot();
        cyc(1'b0, 1'b1, 1'b0, 32'h8000_0003);
        ticks(1); rd("R3 step 1", 1'b1, 32'h2);
        ticks(1); rd("R3 step 2", 1'b1, 32'h1);
        ticks(1); rd("R3 step 3", 1'b1, 32'h0);
        chk("R4 no irq before N+1", {31'b0, irq_o}, 32'h0);
        ticks(1);
        chk("R4 irq after N+1", {31'b0, irq_o}, 32'h1);
        rd("R5 enable cleared", 1'b0, 32'h0000_0003);
        rd("R9 status pending", 1'b1, 32'h4000_0000);
        ticks(4);
        rd("R5 count held at 0", 1'b1, 32'h4000_0000);
        rd("R9 read keeps irq", 1'b1, 32'h4000_0000);
        chk("R11 level held", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 32'hBFFF_FFFF);
        chk("R10 bit30 zero no effect", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        chk("R10 clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_zero_load();
        cyc(1'b0, 1'b1, 1'b0, 32'h8000_0000);
        ticks(1);
        chk("R4 load 0 first tick", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
    endtask

    task automatic t_periodic();
        cyc(1'b0, 1'b1, 1'b0, 32'hC000_0002);
        ticks(3);
        chk("R6 first expiry", {31'b0, irq_o}, 32'h1);
        rd("R6 reloaded", 1'b1, 32'h4000_0002);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        ticks(2);
        chk("R6 not yet", {31'b0, irq_o}, 32'h0);
        ticks(1);
        chk("R6 second expiry", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        rd("R7 stopped count", 1'b1, 32'h0);
        ticks(5);
        chk("R7 no irq after stop", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_restart();
        cyc(1'b0, 1'b1, 1'b0, 32'h8000_0005);
        ticks(2);
        rd("R8 before restart", 1'b1, 32'h3);
        cyc(1'b0, 1'b1, 1'b0, 32'h8000_0001);
        rd("R8 restarted", 1'b1, 32'h1);
        ticks(1);
        chk("R8 no early irq", {31'b0, irq_o}, 32'h0);
        ticks(1);
        chk("R8 expiry from new value", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        cyc(1'b1, 1'b1, 1'b0, 32'h8000_0004);
        rd("R8 write beats tick", 1'b1, 32'h4);
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    task automatic t_set_vs_clr();
        cyc(1'b0, 1'b1, 1'b0, 32'hC000_0000);
        ticks(1);
        chk("R10 setup pending", {31'b0, irq_o}, 32'h1);
        cyc(1'b1, 1'b1, 1'b1, 32'h4000_0000);
        chk("R10 expiry wins over clear", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, 32'h4000_0000);
        chk("R10 final clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_max();
        cyc(1'b0, 1'b1, 1'b0, 32'h9FFF_FFFF);
        rd("R12 ctrl max", 1'b0, 32'h9FFF_FFFF);
        rd("R12 stat max", 1'b1, 32'h1FFF_FFFF);
        ticks(1);
        rd("R12 first step", 1'b1, 32'h1FFF_FFFE);
        chk("R12 no irq", {31'b0, irq_o}, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_oneshot();
        t_zero_load();
        t_periodic();
        t_restart();
        t_set_vs_clr();
        t_max();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule